// File: doc/BRIEF.md
# I/O Privilege and Sensitive-Instruction Checker

This block decides, for one decoded instruction at a time, whether a 32-bit processor model may run it or must take a general-protection fault. Each request carries the instruction class, the execution mode, the current privilege level, the I/O privilege level, a port number with access size, and the current task's bitmap base and segment limit. Flag and interrupt instructions are judged by privilege rules alone. Port accesses may also need a look at the task's I/O permission bitmap.

When the bitmap is needed, the checker reads the covered bitmap bytes one at a time over a request/acknowledge byte interface. It then gives a one-cycle verdict. Requests enter through a valid/ready pair: `in_ready` is low while a bitmap walk is in progress. A request whose `in_valid` is high in a cycle where `in_ready` is low is neither accepted nor consumed. The requester must hold every request field steady until the edge at which it is accepted. The verdict is a pulse with no back-pressure, so the consumer must take it in the cycle it appears.

Top module: `iopriv_checker`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy`, `out_valid`, `out_allow`, `out_fault` and `bm_req` are low and `in_ready` is high.
- R2: In real mode (mode code 0) and the unused mode code 3, every class is allowed. The verdict comes in the cycle after acceptance and no bitmap byte is read.
- R3: In virtual-8086 mode (mode code 2), the sensitive classes fault when IOPL is below 3 and are allowed when IOPL is 3, whatever the privilege input holds, because the effective privilege there is 3. The sensitive class codes are: 0 flag-clear, 1 flag-set, 2 flags-push, 3 flags-pop, 4 software interrupt, 5 interrupt return. The verdict comes in the cycle after acceptance.
- R4: In virtual-8086 mode, the port classes (6 in, 7 string in, 8 out, 9 string out) ignore IOPL and always go through the bitmap.
- R5: In protected mode (mode code 1), a port class with privilege at or below IOPL is allowed in the cycle after acceptance with no bitmap read. All non-port classes are allowed in the same way.
- R6: In protected mode, a port class with privilege above IOPL goes through the bitmap.
- R7: Port p maps to bit p mod 8 of the byte at address base + p/8. The access size code is 0 for 1 byte, 1 for 2 bytes, and 2 or 3 for 4 bytes, and the access covers every port from p up to p+size-1. Bitmap bytes are read in ascending order, and an access that crosses a byte boundary reads two bytes. The walk stops at the first byte that has a covered bit set, and the verdict is a fault. The access is allowed only when every covered bit is clear.
- R8: A bitmap byte whose address is above the segment limit is taken as all ones. It is never requested, and the access faults.
- R9: `bm_req` stays high with `bm_addr` steady until `bm_ack` is seen, and each acknowledge completes one byte. `busy` is high from the cycle after a bitmap request is accepted until the verdict, and `in_ready` equals not `busy`.
- R10: Each verdict is a single-cycle `out_valid` with exactly one of `out_allow`/`out_fault` set. The bitmap base and limit are sampled at acceptance, so later changes to them do not affect the walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Checker can take a request |
| in_class | input | 4 | Instruction class code |
| in_mode | input | 2 | Execution mode code |
| in_cpl | input | 2 | Current privilege level |
| in_iopl | input | 2 | I/O privilege level |
| in_port | input | 16 | Port number |
| in_size | input | 2 | Access size code |
| in_bmp_base | input | 32 | Address of the task's bitmap byte 0 |
| in_seg_limit | input | 32 | Highest valid bitmap byte address |
| bm_req | output | 1 | Bitmap byte read request |
| bm_addr | output | 32 | Bitmap byte address |
| bm_ack | input | 1 | Read acknowledge; `bm_data` is valid with it |
| bm_data | input | 8 | Bitmap byte |
| busy | output | 1 | Bitmap walk in progress |
| out_valid | output | 1 | Verdict pulse |
| out_allow | output | 1 | Verdict: allowed |
| out_fault | output | 1 | Verdict: general-protection fault |

## Verification
A verdict that needs no bitmap is due in the first cycle after the accepting edge. A walk raises `busy` in that same cycle. An out-of-limit first byte gives its fault one cycle later, and a byte that is read gives its verdict in the cycle after the edge that carries its acknowledge. The bench drives on falling edges and samples on falling edges. It checks that immediate verdicts appear at the first sample after acceptance. For walks, it waits a bounded number of cycles, then compares the verdict, the number of bytes read and their addresses with a reference model. A slow memory model holds off acknowledges, so the bench can confirm that the request, the address and the back-pressure stay steady in each waiting cycle.

// File: rtl/iopriv_pkg.sv
package iopriv_pkg;

  typedef enum logic [1:0] {
    M_REAL = 2'd0,
    M_PROT = 2'd1,
    M_V86  = 2'd2,
    M_RSVD = 2'd3
  } exec_mode_e;

  // class codes 0..5: flag/interrupt group, 6..9: port group
  localparam logic [3:0] CLS_LAST_SENS = 4'd5;
  localparam logic [3:0] CLS_PORT_LO   = 4'd6;
  localparam logic [3:0] CLS_PORT_HI   = 4'd9;

  typedef struct packed {
    logic need_bmp;
    logic fault;
  } verdict_t;

  function automatic logic is_sensitive(input logic [3:0] c);
    return c <= CLS_LAST_SENS;
  endfunction

  function automatic logic is_port_io(input logic [3:0] c);
    return (c >= CLS_PORT_LO) && (c <= CLS_PORT_HI);
  endfunction

endpackage

// File: rtl/iopriv_rules.sv
module iopriv_rules
  import iopriv_pkg::*;
(
  input  logic [3:0] cls,
  input  logic [1:0] mode,
  input  logic [1:0] cpl,
  input  logic [1:0] iopl,
  output verdict_t   verdict
);

  logic [1:0] eff_cpl;

  always_comb begin
    // virtual-8086 code always runs at the least privileged level
    eff_cpl = (exec_mode_e'(mode) == M_V86) ? 2'd3 : cpl;
    verdict = '0;
    case (exec_mode_e'(mode))
      M_V86: begin
        if (is_sensitive(cls))
          verdict.fault = (eff_cpl > iopl);
        else if (is_port_io(cls))
          verdict.need_bmp = 1'b1;
      end
      M_PROT: begin
        if (is_port_io(cls) && (eff_cpl > iopl))
          verdict.need_bmp = 1'b1;
      end
      default: verdict = '0;
    endcase
  end

endmodule

// File: rtl/iopriv_span.sv
module iopriv_span #(
  parameter int PORT_W = 16,
  localparam int OFF_W = PORT_W - 2
) (
  input  logic [PORT_W-1:0] port,
  input  logic [1:0]        size,
  output logic [OFF_W-1:0]  first_off,
  output logic [7:0]        mask_lo,
  output logic [7:0]        mask_hi,
  output logic              two_bytes
);

  logic [15:0] lane;
  logic [15:0] shifted;

  always_comb begin
    case (size)
      2'd0:    lane = 16'h0001;
      2'd1:    lane = 16'h0003;
      default: lane = 16'h000F;
    endcase
    shifted   = lane << port[2:0];
    mask_lo   = shifted[7:0];
    mask_hi   = shifted[15:8];
    two_bytes = |shifted[15:8];
    first_off = OFF_W'(port[PORT_W-1:3]);
  end

endmodule

// File: rtl/iopriv_walker.sv
module iopriv_walker #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] limit,
  input  logic [OFF_W-1:0]  first_off,
  input  logic [7:0]        mask_lo,
  input  logic [7:0]        mask_hi,
  input  logic              two_bytes,
  output logic              bm_req,
  output logic [ADDR_W-1:0] bm_addr,
  input  logic              bm_ack,
  input  logic [7:0]        bm_data,
  output logic              busy,
  output logic              done,
  output logic              fault
);

  typedef enum logic {W_IDLE, W_READ} wstate_e;

  wstate_e           st;
  logic [ADDR_W-1:0] base_q, lim_q;
  logic [OFF_W-1:0]  off_q;
  logic [7:0]        mask_q, mask_nxt_q;
  logic              more_q;
  logic [ADDR_W:0]   cur_addr;
  logic              in_range;

  assign cur_addr = {1'b0, base_q} + (ADDR_W + 1)'(off_q);
  assign in_range = cur_addr <= {1'b0, lim_q};
  assign bm_addr  = cur_addr[ADDR_W-1:0];
  assign bm_req   = (st == W_READ) && in_range;
  assign busy     = (st == W_READ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= W_IDLE;
      base_q     <= '0;
      lim_q      <= '0;
      off_q      <= '0;
      mask_q     <= '0;
      mask_nxt_q <= '0;
      more_q     <= 1'b0;
      done       <= 1'b0;
      fault      <= 1'b0;
    end else begin
      done  <= 1'b0;
      fault <= 1'b0;
      case (st)
        W_IDLE: begin
          if (start) begin
            base_q     <= base;
            lim_q      <= limit;
            off_q      <= first_off;
            mask_q     <= mask_lo;
            mask_nxt_q <= mask_hi;
            more_q     <= two_bytes;
            st         <= W_READ;
          end
        end
        W_READ: begin
          if (!in_range) begin
            done  <= 1'b1;
            fault <= 1'b1;
            st    <= W_IDLE;
          end else if (bm_ack) begin
            if (|(bm_data & mask_q)) begin
              done  <= 1'b1;
              fault <= 1'b1;
              st    <= W_IDLE;
            end else if (more_q) begin
              off_q  <= off_q + 1'b1;
              mask_q <= mask_nxt_q;
              more_q <= 1'b0;
            end else begin
              done <= 1'b1;
              st   <= W_IDLE;
            end
          end
        end
        default: st <= W_IDLE;
      endcase
    end
  end

  // R9: an unanswered request is held with the same address
  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bm_req && !bm_ack |=> bm_req && $stable(bm_addr));

  // R8: a request never targets a byte above the sampled limit
  p_no_read_past_limit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bm_req |-> {1'b0, bm_addr} <= {1'b0, lim_q});

  // R9: a finished walk leaves the walker free
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

// File: rtl/iopriv_checker.sv
module iopriv_checker
  import iopriv_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PORT_W = 16,
  localparam int OFF_W = PORT_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [3:0]        in_class,
  input  logic [1:0]        in_mode,
  input  logic [1:0]        in_cpl,
  input  logic [1:0]        in_iopl,
  input  logic [PORT_W-1:0] in_port,
  input  logic [1:0]        in_size,
  input  logic [ADDR_W-1:0] in_bmp_base,
  input  logic [ADDR_W-1:0] in_seg_limit,
  output logic              bm_req,
  output logic [ADDR_W-1:0] bm_addr,
  input  logic              bm_ack,
  input  logic [7:0]        bm_data,
  output logic              busy,
  output logic              out_valid,
  output logic              out_allow,
  output logic              out_fault
);

  verdict_t         verdict;
  logic [OFF_W-1:0] first_off;
  logic [7:0]       mask_lo, mask_hi;
  logic             two_bytes;
  logic             accept, wk_busy, wk_done, wk_fault;
  logic             imm_q, imm_fault_q;

  iopriv_rules u_rules (
    .cls     (in_class),
    .mode    (in_mode),
    .cpl     (in_cpl),
    .iopl    (in_iopl),
    .verdict (verdict)
  );

  iopriv_span #(.PORT_W(PORT_W)) u_span (
    .port      (in_port),
    .size      (in_size),
    .first_off (first_off),
    .mask_lo   (mask_lo),
    .mask_hi   (mask_hi),
    .two_bytes (two_bytes)
  );

  iopriv_walker #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_walker (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept && verdict.need_bmp),
    .base      (in_bmp_base),
    .limit     (in_seg_limit),
    .first_off (first_off),
    .mask_lo   (mask_lo),
    .mask_hi   (mask_hi),
    .two_bytes (two_bytes),
    .bm_req    (bm_req),
    .bm_addr   (bm_addr),
    .bm_ack    (bm_ack),
    .bm_data   (bm_data),
    .busy      (wk_busy),
    .done      (wk_done),
    .fault     (wk_fault)
  );

  assign in_ready = !wk_busy;
  assign busy     = wk_busy;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imm_q       <= 1'b0;
      imm_fault_q <= 1'b0;
    end else begin
      imm_q       <= accept && !verdict.need_bmp;
      imm_fault_q <= accept && !verdict.need_bmp && verdict.fault;
    end
  end

  assign out_valid = imm_q || wk_done;
  assign out_fault = imm_q ? imm_fault_q : wk_fault;
  assign out_allow = out_valid && !out_fault;

  // R10: every verdict names exactly one outcome, and none shows while idle
  p_one_outcome_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_allow ^ out_fault));
  p_quiet_outcome_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !out_allow && !out_fault);

  // R2: real and unused mode codes always allow, next cycle
  p_real_allow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (in_mode == M_REAL || in_mode == M_RSVD) |=> out_valid && out_allow);

  // R3: sensitive class in virtual-8086 mode with IOPL below 3 faults
  p_v86_sens_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_mode == M_V86 && in_class <= 4'd5 && in_iopl != 2'd3
    |=> out_valid && out_fault);

  // R4: port access in virtual-8086 mode always starts a walk
  p_v86_port_walk_r4: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_mode == M_V86 && in_class >= 4'd6 && in_class <= 4'd9
    |=> busy && !out_valid);

  // R5: privileged enough in protected mode means no walk
  p_prot_fast_r5: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_mode == M_PROT && in_cpl <= in_iopl
    |=> out_valid && out_allow && !busy);

  // R9: back-pressure follows the walk
  p_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !in_ready);

endmodule

// File: tb/test_iopriv_checker.sv
module test_iopriv_checker;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_class = '0;
  logic [1:0]  in_mode = '0, in_cpl = '0, in_iopl = '0, in_size = '0;
  logic [15:0] in_port = '0;
  logic [31:0] in_bmp_base = '0, in_seg_limit = '0;
  logic        bm_req, bm_ack;
  logic [31:0] bm_addr;
  logic [7:0]  bm_data;
  logic        busy, out_valid, out_allow, out_fault;

  int errs = 0, checks = 0, cyc = 0;
  int base_cfg = 16, limit_cfg = 40, ack_lat = 1;
  logic [7:0] mem [0:63];
  int rd_cnt = 0, dly = 0;
  logic [31:0] rd_log [0:3];

  always #2 clk = ~clk;

  iopriv_checker i_iopriv_checker (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_class(in_class), .in_mode(in_mode), .in_cpl(in_cpl), .in_iopl(in_iopl),
    .in_port(in_port), .in_size(in_size), .in_bmp_base(in_bmp_base),
    .in_seg_limit(in_seg_limit), .bm_req(bm_req), .bm_addr(bm_addr),
    .bm_ack(bm_ack), .bm_data(bm_data), .busy(busy), .out_valid(out_valid),
    .out_allow(out_allow), .out_fault(out_fault)
  );

  // bitmap memory model with configurable acknowledge delay
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bm_ack  <= 1'b0;
      bm_data <= '0;
      dly     <= 0;
    end else if (bm_req && !bm_ack) begin
      if (dly >= ack_lat) begin
        bm_ack  <= 1'b1;
        bm_data <= mem[bm_addr[5:0]];
        dly     <= 0;
      end else dly <= dly + 1;
    end else begin
      bm_ack <= 1'b0;
      dly    <= 0;
    end
  end

  always_ff @(posedge clk) begin
    if (bm_req && bm_ack) begin
      rd_log[rd_cnt % 4] <= bm_addr;
      rd_cnt <= rd_cnt + 1;
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errs++; checks++;
      $display("FAIL R9 watchdog expired: act=%0d exp<%0d cycles", cyc, 150000);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic void ref_eval(input int cls, input int mode, input int cpl,
                                   input int iopl, input int port, input int size,
                                   output bit flt, output int nrd, output bit bmp);
    bit sens = (cls <= 5);
    bit io   = (cls >= 6 && cls <= 9);
    int ecpl = (mode == 2) ? 3 : cpl;
    int nb   = (size == 0) ? 1 : (size == 1) ? 2 : 4;
    flt = 0; nrd = 0; bmp = 0;
    if (mode == 2 && sens) flt = (ecpl > iopl);
    else if (io && (mode == 2 || (mode == 1 && ecpl > iopl))) begin
      bmp = 1;
      for (int b = port / 8; b <= (port + nb - 1) / 8; b++) begin
        if (base_cfg + b > limit_cfg) begin flt = 1; break; end
        nrd++;
        for (int p = port; p < port + nb; p++)
          if (p / 8 == b && mem[base_cfg + b][p % 8]) flt = 1;
        if (flt) break;
      end
    end
  endfunction

  task automatic do_req(input int cls, input int mode, input int cpl, input int iopl,
                        input int port, input int size, input string tag);
    bit eflt, ebmp, seen;
    int enrd, rd0, lat;
    ref_eval(cls, mode, cpl, iopl, port, size, eflt, enrd, ebmp);
    @(negedge clk);
    for (int w = 0; w < 50 && !in_ready; w++) @(negedge clk);
    in_class = 4'(cls); in_mode = 2'(mode); in_cpl = 2'(cpl); in_iopl = 2'(iopl);
    in_port = 16'(port); in_size = 2'(size);
    in_bmp_base = 32'(base_cfg); in_seg_limit = 32'(limit_cfg);
    in_valid = 1'b1;
    rd0 = rd_cnt;
    @(negedge clk);
    in_valid = 1'b0;
    if (ebmp) chk(busy && !in_ready, {tag, " walk holds busy (R9)"}, int'(busy), 1);
    seen = 0; lat = 0;
    for (int w = 0; w < 50; w++) begin
      if (out_valid) begin seen = 1; break; end
      lat++;
      @(negedge clk);
    end
    chk(seen, {tag, " verdict arrives"}, int'(seen), 1);
    chk(out_fault == eflt && out_allow == !eflt, {tag, " verdict fault"}, int'(out_fault), int'(eflt));
    chk(rd_cnt - rd0 == enrd, {tag, " bytes read"}, rd_cnt - rd0, enrd);
    if (!ebmp) chk(lat == 0, {tag, " immediate latency"}, lat, 0);
    @(negedge clk);
    chk(!out_valid, {tag, " single-cycle pulse (R10)"}, int'(out_valid), 0);
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 64; i++) mem[i] = 8'h00;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(!busy && !out_valid && !out_allow && !out_fault && !bm_req && in_ready,
        "R1 outputs during reset", int'(busy | out_valid | bm_req), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !out_valid && !bm_req && in_ready, "R1 outputs after reset",
        int'(busy | out_valid | bm_req), 0);
  endtask

  task automatic t_real();
    clear_mem(); mem[18] = 8'hFF;
    do_req(8, 0, 3, 0, 16'h12, 0, "R2 real out over set bit");
    do_req(0, 0, 3, 0, 0, 0, "R2 real flag-clear");
    do_req(6, 3, 3, 0, 16'h12, 0, "R2 unused mode code");
  endtask

  task automatic t_v86_sens();
    do_req(0, 2, 0, 1, 0, 0, "R3 v86 clear, cpl0 iopl1 faults");
    do_req(4, 2, 0, 0, 0, 0, "R3 v86 soft int faults");
    do_req(5, 2, 3, 3, 0, 0, "R3 v86 iret iopl3 allowed");
  endtask

  task automatic t_v86_io();
    clear_mem();
    do_req(6, 2, 0, 0, 16'h12, 0, "R4 v86 in, iopl0, clear bit");
    mem[18] = 8'h04;
    do_req(9, 2, 3, 3, 16'h12, 0, "R4 v86 outs, iopl3, set bit");
  endtask

  task automatic t_prot();
    clear_mem(); mem[18] = 8'h04;
    do_req(8, 1, 0, 0, 16'h12, 0, "R5 prot out cpl<=iopl");
    do_req(0, 1, 3, 0, 0, 0, "R5 prot flag-clear allowed");
    do_req(8, 1, 3, 0, 16'h12, 0, "R6 prot out cpl>iopl set bit");
    do_req(7, 1, 2, 1, 16'h13, 0, "R6 prot ins cpl>iopl clear bit");
  endtask

  task automatic t_span();
    clear_mem(); mem[18] = 8'h01;
    do_req(6, 2, 3, 0, 16'h0E, 2, "R7 4-byte cross, high byte set");
    chk(rd_log[(rd_cnt - 2) % 4] == 32'd17 && rd_log[(rd_cnt - 1) % 4] == 32'd18,
        "R7 ascending addresses", int'(rd_log[(rd_cnt - 2) % 4]), 17);
    mem[18] = 8'h10;
    do_req(6, 2, 3, 0, 16'h0E, 2, "R7 4-byte cross, uncovered bit");
    clear_mem(); mem[17] = 8'h80;
    do_req(8, 2, 3, 0, 16'h0F, 1, "R7 stop at first faulting byte");
    clear_mem(); mem[18] = 8'h08;
    do_req(8, 2, 3, 0, 16'h12, 1, "R7 2-byte within byte, bit3 set");
  endtask

  task automatic t_limit();
    clear_mem();
    do_req(6, 2, 3, 0, 16'hC8, 0, "R8 byte past limit");
    do_req(6, 2, 3, 0, 16'hC7, 1, "R8 second byte past limit");
    do_req(6, 2, 3, 0, 16'hC0, 0, "R8 last byte in limit allowed");
  endtask

  task automatic t_handshake();
    clear_mem(); ack_lat = 3;
    @(negedge clk);
    in_class = 4'd6; in_mode = 2'd2; in_cpl = 2'd3; in_iopl = 2'd0;
    in_port = 16'h12; in_size = 2'd0;
    in_bmp_base = 32'd16; in_seg_limit = 32'd40; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; in_bmp_base = 32'd30;
    for (int k = 0; k < 3; k++) begin
      chk(bm_req && bm_addr == 32'd18 && !in_ready, "R9 request held, R10 base sampled",
          int'(bm_addr), 18);
      @(negedge clk);
    end
    for (int w = 0; w < 20 && !out_valid; w++) @(negedge clk);
    chk(out_valid && out_allow, "R9 slow ack verdict", int'(out_allow), 1);
    ack_lat = 1;
  endtask

  task automatic t_sweep();
    clear_mem(); mem[18] = 8'h04;
    for (int m = 0; m < 4; m++)
      for (int c = 0; c < 11; c++)
        for (int pl = 0; pl < 4; pl += 3)
          for (int io = 0; io < 4; io += 3)
            do_req(c, m, pl, io, 16'h12, 0, "R2_R6 class/mode sweep");
  endtask

  initial begin
    t_reset();
    t_real();
    t_v86_sens();
    t_v86_io();
    t_prot();
    t_span();
    t_limit();
    t_handshake();
    t_sweep();
    summary();
    $finish;
  end

endmodule